// File: doc/BRIEF.md
# Byte-Masked Common-I/O Synchronous SRAM

This block models a clocked single-port memory whose data pins are shared between reads and writes. A word is made of byte lanes. Each lane holds eight data bits and one extra parity-style bit, and the extra bit is always written together with its lane's byte. A command is issued in one cycle: chip select, write enable, address and the per-lane write selects. The data for that command moves in the following cycle. For a write, the data arrives on `data_in` in that next cycle, and only the selected lanes change. For a read, the stored word is presented on `data_out` in that next cycle.

The pad is not modelled. A `drive_en` output stands in for the tri-state enable, with separate `data_in` and `data_out` ports. `drive_en` rises only when a selected read is being returned and output enable is low. It stays low for the whole data cycle of a write, whatever output enable says. A partial-word update needs no read-modify-write: one masked write does it. The lane count is a parameter, meant for 2, 4 or 8 lanes.

Top module: `bytemask_sram`

## Requirements
- R1: A write changes only the lanes whose `lane_we_n` bit is 0 in the command cycle. The other lanes keep their contents.
- R2: Lane i occupies bits `[i*LANE_W +: LANE_W]` of the word. The top bit of each lane is its extra parity-style bit, and it is written or kept together with that lane.
- R3: The write data is taken from `data_in` in the cycle after the write command. Whatever is on `data_in` during the command cycle is not stored.
- R4: `drive_en` is 0 throughout the data cycle of a write, even when `oe_n` is 0.
- R5: In the cycle after a selected read command, `data_out` holds the addressed word, and `drive_en` is 1 exactly when `oe_n` is 0.
- R6: While `oe_n` is 1, `drive_en` is 0. Whenever `drive_en` is 0, `data_out` is all zeros.
- R7: A cycle with `sel_n` at 1 issues no command. Memory is unchanged, and `drive_en` is 0 in the next cycle.
- R8: A write with every `lane_we_n` bit at 1 leaves the word unchanged.
- R9: While reset is applied, and right after it, `drive_en` is 0 and `data_out` is zero.
- R10: A read command issued in the data cycle of a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low (1 = read) |
| addr | input | ADDR_W | Word address, sampled in the command cycle |
| lane_we_n | input | LANES | Per-lane write selects, active low, sampled in the command cycle |
| oe_n | input | 1 | Output enable, active low, acts in the current cycle |
| data_in | input | LANES*LANE_W | Write data from the pad, taken in the data cycle |
| data_out | output | LANES*LANE_W | Read data toward the pad, zero when not driving |
| drive_en | output | 1 | Pad driver enable |

## Verification
The bench sweeps every lane-mask value over every address of a small memory and compares each word it reads back with a shadow copy it computes. A design that writes the whole word, or that leaves the parity bit out of a lane, returns the wrong word in that sweep. The bench places junk data on `data_in` during each write command cycle and holds `oe_n` low through the data cycle. A design that samples data one cycle early stores the junk, and one that obeys output enable during a write drives `drive_en` high. The bench also covers a deselected write, a write with no lanes selected, a read with `oe_n` high, and a read issued in a write's data cycle. A design that lets these through, or that needs forwarding it does not have, returns stale data or raises `drive_en` at the wrong time.

// File: rtl/sram_pkg.sv
// Package: shared types for the byte-masked SRAM.
// Assumes: one command per cycle, classified as none, read or write.
package sram_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } sram_op_e;
endpackage

// File: rtl/sram_cmd_stage.sv
// Module: sram_cmd_stage
// Registers the command of cycle N so that its data phase runs in cycle N+1.
// Assumes: the inputs are synchronous to clk; the per-lane selects are active low.
module sram_cmd_stage
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_we_n,
    output sram_op_e          op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  lanes_q
);
    sram_op_e op_d;

    // Decode which operation the current cycle issues.
    always_comb begin
        if (sel_n)     op_d = OP_NONE;
        else if (we_n) op_d = OP_READ;
        else           op_d = OP_WRITE;
    end

    // Hold the operation kind, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) op_q <= OP_NONE;
        else        op_q <= op_d;
    end

    // Hold the address and the active-high lane enables; these are data, so no reset.
    always_ff @(posedge clk) begin
        addr_q  <= addr;
        lanes_q <= ~lane_we_n;
    end
endmodule

// File: rtl/sram_lane_array.sv
// Module: sram_lane_array
// Storage split into one array per byte lane, so that each lane is written on its own.
// Assumes: the read is asynchronous from a registered address; a write lands at the clock edge.
module sram_lane_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Store this lane's byte and extra bit when the write selects it.
        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        // Present this lane of the addressed word.
        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end
endmodule

// File: rtl/sram_bus_ctrl.sv
// Module: sram_bus_ctrl
// Controls the direction of the shared bus: drives only for a read return with
// output enable low, and never during a write data phase.
// Assumes: oe_n acts in the current cycle, as an asynchronous output enable.
module sram_bus_ctrl
    import sram_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  sram_op_e          op_q,
    input  logic              oe_n,
    input  logic [WORD_W-1:0] rd_data,
    output logic              drive_en,
    output logic [WORD_W-1:0] data_out
);
    // Drive enable: a read is returning and output enable is low.
    always_comb begin
        drive_en = (op_q == OP_READ) && !oe_n;
    end

    // Output data: the read word while driving, otherwise zero.
    always_comb begin
        data_out = drive_en ? rd_data : '0;
    end
endmodule

// File: rtl/bytemask_sram.sv
// Module: bytemask_sram (top)
// Single-port synchronous SRAM with a common data bus, byte-lane write masking
// and a late write data phase.
// Assumes: LANES is 2, 4 or 8; LANE_W includes the extra parity-style bit.
module bytemask_sram
    import sram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_n,
    input  logic                    we_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] data_in,
    output logic [LANES*LANE_W-1:0] data_out,
    output logic                    drive_en
);
    localparam int WORD_W = LANES * LANE_W;

    sram_op_e          op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  lanes_q;
    logic [WORD_W-1:0] rd_data;
    logic              wr_en;

    sram_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) i_cmd (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .we_n(we_n), .addr(addr),
        .lane_we_n(lane_we_n), .op_q(op_q), .addr_q(addr_q), .lanes_q(lanes_q)
    );

    // A write commits in its data phase, one cycle after the command.
    always_comb begin
        wr_en = (op_q == OP_WRITE);
    end

    sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
        .clk(clk), .wr_en(wr_en), .wr_addr(addr_q), .wr_lanes(lanes_q),
        .wr_data(data_in), .rd_addr(addr_q), .rd_data(rd_data)
    );

    sram_bus_ctrl #(.WORD_W(WORD_W)) i_bus (
        .op_q(op_q), .oe_n(oe_n), .rd_data(rd_data),
        .drive_en(drive_en), .data_out(data_out)
    );
endmodule

// File: rtl/sram_checker.sv
// Module: sram_checker
// Bus-direction properties of bytemask_sram, attached with bind below.
// Assumes: the same clock and synchronous active-low reset as the top.
module sram_checker #(
    parameter int WORD_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              drive_en,
    input logic [WORD_W-1:0] data_out
);
    p_write_phase_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !we_n) |=> !drive_en);

    p_read_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && we_n) |=> (drive_en == !oe_n));

    p_oe_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !drive_en);

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> (data_out == '0));

    p_deselect_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !drive_en);
endmodule

bind bytemask_sram sram_checker #(.WORD_W(LANES*LANE_W)) i_sram_checker (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .we_n(we_n), .oe_n(oe_n),
    .drive_en(drive_en), .data_out(data_out)
);

// File: tb/test_bytemask_sram.sv
// Bench: sweeps every lane mask over every address of a 16-word, 4-lane memory
// against a shadow array computed here.
module test_bytemask_sram;
    localparam int CLK_P  = 10;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int ADDR_W = 4;
    localparam int WORD_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel_n = 1'b1;
    logic              we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [LANES-1:0]  lane_we_n = '1;
    logic              oe_n = 1'b1;
    logic [WORD_W-1:0] data_in = '0;
    logic [WORD_W-1:0] data_out;
    logic              drive_en;

    logic [WORD_W-1:0] shadow [DEPTH];
    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    bytemask_sram #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) i_bytemask_sram (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .we_n(we_n), .addr(addr),
        .lane_we_n(lane_we_n), .oe_n(oe_n), .data_in(data_in),
        .data_out(data_out), .drive_en(drive_en)
    );

    task automatic check(input string req, input logic [WORD_W-1:0] act,
                         input logic [WORD_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] pattern(input int a, input int m, input int pass);
        logic [WORD_W-1:0] w;
        for (int i = 0; i < LANES; i++)
            w[i*LANE_W +: LANE_W] = LANE_W'((a*37 + m*11 + i*83 + pass*151 + 5) % 512);
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] merge(input logic [WORD_W-1:0] old,
                                                input logic [WORD_W-1:0] d,
                                                input logic [LANES-1:0] mask_n);
        logic [WORD_W-1:0] w = old;
        for (int i = 0; i < LANES; i++)
            if (!mask_n[i]) w[i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
        return w;
    endfunction

    // Write command, then data phase; junk on data_in during the command (R3).
    task automatic write_word(input int a, input logic [LANES-1:0] m,
                              input logic [WORD_W-1:0] d, input bit rd_same);
        @(negedge clk);
        sel_n = 1'b0; we_n = 1'b0; addr = ADDR_W'(a); lane_we_n = m;
        data_in = ~d; oe_n = 1'b0;
        @(negedge clk);
        sel_n = rd_same ? 1'b0 : 1'b1; we_n = 1'b1; lane_we_n = ~m; data_in = d; oe_n = 1'b0;
        #(CLK_P/4);
        check("R4 drive_en in write data phase", WORD_W'(drive_en), '0);
        shadow[a] = merge(shadow[a], d, m);
    endtask

    // Read command, then sample in the return cycle.
    task automatic read_word(input int a, input logic oe, input string req);
        @(negedge clk);
        sel_n = 1'b0; we_n = 1'b1; addr = ADDR_W'(a); oe_n = oe; data_in = '0;
        @(negedge clk);
        sel_n = 1'b1; oe_n = oe;
        #(CLK_P/4);
        check({req, " drive_en"}, WORD_W'(drive_en), WORD_W'(!oe));
        check({req, " data_out"}, data_out, oe ? '0 : shadow[a]);
    endtask

    initial begin
        #(CLK_P * 100000);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R9: reset state, with a read pending before reset takes hold.
        sel_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 drive_en in reset", WORD_W'(drive_en), '0);
        check("R9 data_out in reset", data_out, '0);
        sel_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 drive_en after reset", WORD_W'(drive_en), '0);

        // Fill every word through all lanes.
        for (int a = 0; a < DEPTH; a++) begin
            shadow[a] = '0;
            write_word(a, '0, pattern(a, 0, 0), 1'b0);
        end
        for (int a = 0; a < DEPTH; a++) read_word(a, 1'b0, "R5 full write");

        // R1/R2/R8: every mask over every address, parity bits included.
        for (int m = 0; m < (1 << LANES); m++) begin
            for (int a = 0; a < DEPTH; a++) begin
                write_word(a, LANES'(m), pattern(a, m, 1), 1'b0);
                read_word(a, 1'b0, (m == (1 << LANES) - 1) ? "R8 no-lane write" : "R1 R2 masked write");
            end
        end

        // R2: flip only the extra bit of one lane.
        for (int i = 0; i < LANES; i++) begin
            logic [WORD_W-1:0] d = shadow[3];
            d[i*LANE_W + LANE_W - 1] = ~d[i*LANE_W + LANE_W - 1];
            write_word(3, ~(LANES'(1) << i), d, 1'b0);
            read_word(3, 1'b0, "R2 extra bit");
        end

        // R6: read with output enable high.
        read_word(5, 1'b1, "R6 oe high");

        // R7: deselected write attempt changes nothing and drives nothing.
        @(negedge clk);
        sel_n = 1'b1; we_n = 1'b0; addr = 4'd7; lane_we_n = '0; oe_n = 1'b0; data_in = '1;
        @(negedge clk);
        we_n = 1'b1; data_in = '1;
        #(CLK_P/4);
        check("R7 drive_en after deselect", WORD_W'(drive_en), '0);
        read_word(7, 1'b0, "R7 deselected write");

        // R10: read issued in the data phase of a write to the same address.
        write_word(9, 4'b0101, pattern(9, 3, 7), 1'b1);
        @(negedge clk);
        sel_n = 1'b1; oe_n = 1'b0;
        #(CLK_P/4);
        check("R10 drive_en", WORD_W'(drive_en), WORD_W'(1));
        check("R10 data_out", data_out, shadow[9]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule